// File: doc/BRIEF.md
# Typed Interrupt Pending Register

This block keeps one pending flag and one enable flag for each interrupt line of a processor core. At elaboration every line gets exactly one of four kinds: software, edge, level or non-maskable. The kind decides what can set the flag and what can clear it. Software lines are set and cleared only by software requests. Edge lines latch when their input rises and are cleared by software. Level lines follow their input. Non-maskable lines latch when their input rises and are cleared when the dispatcher accepts the non-maskable interrupt.

Software set and clear requests carry a bit mask. The block filters each mask by line kind, so a request that names a line of the wrong kind has no effect on that line. The block outputs the raw pending vector and the vector of lines that are both pending and enabled. Interrupt priority selection and vector dispatch are handled by logic outside this block.

Top module: `irqp_typed_pending`

## Requirements
- R1: After reset, `pend_vec`, `en_vec` and `pend_en_vec` are all zero.
- R2: A cycle with `sw_set_vld` high sets, at the next clock edge, every software-kind bit named in `sw_set_mask`. With the default kinds these are bits 3:0.
- R3: A software set request has no effect on edge-kind bits (default 7:4), level-kind bits (default 31:17 and 15:8) or the non-maskable bit (default 16).
- R4: A cycle with `sw_clr_vld` high clears, at the next clock edge, every software-kind and edge-kind bit named in `sw_clr_mask`.
- R5: A software clear request has no effect on level-kind bits or non-maskable bits.
- R6: An edge-kind bit becomes pending one clock edge after its `hw_lines` input rises. It stays pending after the input falls, until software clears it.
- R7: A level-kind pending bit equals its `hw_lines` input as sampled at the previous clock edge. It rises and falls with the input.
- R8: A non-maskable bit latches when its input rises. A cycle with `nmi_take` high clears every non-maskable bit at the next edge. A line held high does not latch again.
- R9: When a new rising input and a clear (software clear or `nmi_take`) reach the same edge or non-maskable bit in the same cycle, the bit ends up set.
- R10: When a software set and a software clear name the same software bit in the same cycle, the bit ends up set.
- R11: A cycle with `en_wr_vld` high loads `en_wr_data` into `en_vec`. `pend_en_vec` is the bitwise AND of `pend_vec` and `en_vec`, and writing the enable never changes `pend_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_set_vld | input | 1 | Software set request strobe |
| sw_set_mask | input | WIDTH | Lines to set (filtered by kind) |
| sw_clr_vld | input | 1 | Software clear request strobe |
| sw_clr_mask | input | WIDTH | Lines to clear (filtered by kind) |
| en_wr_vld | input | 1 | Enable register write strobe |
| en_wr_data | input | WIDTH | New enable register value |
| hw_lines | input | WIDTH | Hardware interrupt inputs |
| nmi_take | input | 1 | Dispatcher accepted the non-maskable interrupt |
| pend_vec | output | WIDTH | Raw pending vector |
| en_vec | output | WIDTH | Enable register value |
| pend_en_vec | output | WIDTH | Pending and enabled lines |

## Verification
The set and clear requests are driven with all-ones masks. This shows that the kind filter, and not the mask, decides which bits move. The hardware inputs are driven as single pulses, held levels and lines that stay high. These patterns separate latching kinds from tracking kinds, and show that a held non-maskable input does not latch a second time. Same-cycle collisions are driven on purpose: a rising input meeting a clear, and a set meeting a clear. These show which update takes precedence. Enable writes are then made over a known pending pattern to show that the gate changes only the gated output.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef enum logic [1:0] {
        IRQK_SW    = 2'd0,
        IRQK_EDGE  = 2'd1,
        IRQK_LEVEL = 2'd2,
        IRQK_NMI   = 2'd3
    } irqk_e;

    // Next value of one pending bit, chosen by the kind of its line.
    function automatic logic irqk_next(irqk_e kind, logic cur, logic set_r,
                                       logic clr_r, logic rise, logic take,
                                       logic lvl);
        logic nxt;
        case (kind)
            IRQK_SW:    nxt = (cur & ~clr_r) | set_r;   // set beats clear (R10)
            IRQK_EDGE:  nxt = (cur & ~clr_r) | rise;    // new edge beats clear (R9)
            IRQK_LEVEL: nxt = lvl;
            default:    nxt = (cur & ~take) | rise;     // non-maskable kind
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/irqp_edge_cap.sv
module irqp_edge_cap #(
    parameter int          WIDTH    = 32,
    parameter logic [31:0] CAP_MASK = 32'h0001_00F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hw_in,
    output logic [WIDTH-1:0] rise
);
    localparam logic [WIDTH-1:0] CapM = CAP_MASK[WIDTH-1:0];

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = hw_in & CapM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = hw_in & CapM & ~st_q.prev;

endmodule

// File: rtl/irqp_pend_core.sv
module irqp_pend_core
    import irqp_pkg::*;
#(
    parameter int          WIDTH     = 32,
    parameter logic [31:0] SW_MASK   = 32'h0000_000F,
    parameter logic [31:0] EDGE_MASK = 32'h0000_00F0,
    parameter logic [31:0] NMI_MASK  = 32'h0001_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_req,
    input  logic [WIDTH-1:0] clr_req,
    input  logic [WIDTH-1:0] rise,
    input  logic             take,
    input  logic [WIDTH-1:0] lvl_in,
    output logic [WIDTH-1:0] pend
);
    localparam logic [WIDTH-1:0] SwM   = SW_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] EdgeM = EDGE_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] NmiM  = NMI_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] LvlM  = ~(SwM | EdgeM | NmiM);

    typedef struct packed {
        logic [WIDTH-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    irqk_e    kind [WIDTH];

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            if (SwM[i])        kind[i] = IRQK_SW;
            else if (EdgeM[i]) kind[i] = IRQK_EDGE;
            else if (NmiM[i])  kind[i] = IRQK_NMI;
            else               kind[i] = IRQK_LEVEL;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDTH; i++) begin
            st_d.pend[i] = irqk_next(kind[i], st_q.pend[i], set_req[i],
                                     clr_req[i], rise[i], take, lvl_in[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    // Level lines mirror the input of the previous edge.
    assert_level_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & LvlM) == ($past(lvl_in) & LvlM)));

    // A software bit only rises after a set request named it.
    assert_sw_rise_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & ~$past(pend) & SwM & ~$past(set_req)) == '0));

    // Edge and non-maskable bits only rise after a captured input edge.
    assert_latch_needs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & ~$past(pend) & (EdgeM | NmiM) & ~$past(rise)) == '0));

    // Non-maskable bits only fall when the dispatcher took the interrupt.
    assert_nmi_fall_needs_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(take) |-> ((~pend & $past(pend) & NmiM) == '0));

endmodule

// File: rtl/irqp_typed_pending.sv
module irqp_typed_pending #(
    parameter int          WIDTH     = 32,
    parameter logic [31:0] SW_MASK   = 32'h0000_000F,
    parameter logic [31:0] EDGE_MASK = 32'h0000_00F0,
    parameter logic [31:0] NMI_MASK  = 32'h0001_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_set_vld,
    input  logic [WIDTH-1:0] sw_set_mask,
    input  logic             sw_clr_vld,
    input  logic [WIDTH-1:0] sw_clr_mask,
    input  logic             en_wr_vld,
    input  logic [WIDTH-1:0] en_wr_data,
    input  logic [WIDTH-1:0] hw_lines,
    input  logic             nmi_take,
    output logic [WIDTH-1:0] pend_vec,
    output logic [WIDTH-1:0] en_vec,
    output logic [WIDTH-1:0] pend_en_vec
);
    localparam logic [31:0]      CapMask = EDGE_MASK | NMI_MASK;
    localparam logic [WIDTH-1:0] SwM     = SW_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ClrM    = SW_MASK[WIDTH-1:0] | EDGE_MASK[WIDTH-1:0];

    typedef struct packed {
        logic [WIDTH-1:0] en;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [WIDTH-1:0] set_req, clr_req, rise;

    always_comb begin
        st_d    = st_q;
        set_req = sw_set_vld ? (sw_set_mask & SwM)  : '0;
        clr_req = sw_clr_vld ? (sw_clr_mask & ClrM) : '0;
        if (en_wr_vld) st_d.en = en_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    irqp_edge_cap #(
        .WIDTH    (WIDTH),
        .CAP_MASK (CapMask)
    ) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_in (hw_lines),
        .rise  (rise)
    );

    irqp_pend_core #(
        .WIDTH     (WIDTH),
        .SW_MASK   (SW_MASK),
        .EDGE_MASK (EDGE_MASK),
        .NMI_MASK  (NMI_MASK)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .rise    (rise),
        .take    (nmi_take),
        .lvl_in  (hw_lines),
        .pend    (pend_vec)
    );

    assign en_vec      = st_q.en;
    assign pend_en_vec = pend_vec & st_q.en;

    // Enable register holds its value unless written.
    assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(en_wr_vld) |-> $stable(en_vec));

endmodule

// File: tb/sim_irqp_typed_pending.sv
module sim_irqp_typed_pending;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_set_vld = 1'b0, sw_clr_vld = 1'b0, en_wr_vld = 1'b0, nmi_take = 1'b0;
    logic [W-1:0] sw_set_mask = '0, sw_clr_mask = '0, en_wr_data = '0, hw_lines = '0;
    logic [W-1:0] pend_vec, en_vec, pend_en_vec;
    int           n_chk = 0, n_fail = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    irqp_typed_pending u0 (
        .clk(clk), .rst_n(rst_n),
        .sw_set_vld(sw_set_vld), .sw_set_mask(sw_set_mask),
        .sw_clr_vld(sw_clr_vld), .sw_clr_mask(sw_clr_mask),
        .en_wr_vld(en_wr_vld), .en_wr_data(en_wr_data),
        .hw_lines(hw_lines), .nmi_take(nmi_take),
        .pend_vec(pend_vec), .en_vec(en_vec), .pend_en_vec(pend_en_vec)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One clock edge; strobes are dropped afterwards. Called at a falling edge.
    task automatic step();
        @(negedge clk);
        sw_set_vld = 1'b0; sw_clr_vld = 1'b0; en_wr_vld = 1'b0; nmi_take = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pend", pend_vec, '0);
        check("R1 en", en_vec, '0);
        check("R1 pend_en", pend_en_vec, '0);
    endtask

    task automatic t_sw_set();
        sw_set_vld = 1'b1; sw_set_mask = '1; step();
        check("R2/R3 set all-ones", pend_vec, 32'h0000_000F);
    endtask

    task automatic t_sw_clear();
        sw_clr_vld = 1'b1; sw_clr_mask = 32'h0000_0005; step();
        check("R4 clr sw", pend_vec, 32'h0000_000A);
    endtask

    task automatic t_edge();
        hw_lines = 32'h0000_0020; step();
        check("R6 edge latch", pend_vec, 32'h0000_002A);
        hw_lines = '0; step();
        check("R6 edge held", pend_vec, 32'h0000_002A);
    endtask

    task automatic t_clr_kinds();
        hw_lines = 32'h0001_0100; step();
        check("R7/R8 level+nmi in", pend_vec, 32'h0001_012A);
        sw_clr_vld = 1'b1; sw_clr_mask = '1; step();
        check("R4/R5 clr all-ones", pend_vec, 32'h0001_0100);
    endtask

    task automatic t_level();
        hw_lines = 32'h0001_0000; step();
        check("R7 level falls", pend_vec, 32'h0001_0000);
        sw_set_vld = 1'b1; sw_set_mask = 32'h0001_0280; step();
        check("R3 set ignored", pend_vec, 32'h0001_0000);
    endtask

    task automatic t_nmi();
        nmi_take = 1'b1; step();
        check("R8 take clears", pend_vec, '0);
        step();
        check("R8 held no relatch", pend_vec, '0);
    endtask

    task automatic t_race();
        hw_lines = '0; step();
        check("R9 idle", pend_vec, '0);
        hw_lines = 32'h0001_0040; sw_clr_vld = 1'b1; sw_clr_mask = '1; nmi_take = 1'b1;
        step();
        check("R9 edge beats clear", pend_vec, 32'h0001_0040);
    endtask

    task automatic t_setclr();
        sw_set_vld = 1'b1; sw_set_mask = 32'h4;
        sw_clr_vld = 1'b1; sw_clr_mask = 32'h4; step();
        check("R10 set beats clear", pend_vec, 32'h0001_0044);
    endtask

    task automatic t_enable();
        en_wr_vld = 1'b1; en_wr_data = 32'h0000_0044; step();
        check("R11 en value", en_vec, 32'h0000_0044);
        check("R11 gated", pend_en_vec, 32'h0000_0044);
        en_wr_vld = 1'b1; en_wr_data = 32'hFFFF_0000; step();
        check("R11 gated nmi", pend_en_vec, 32'h0001_0000);
        check("R11 pend untouched", pend_vec, 32'h0001_0044);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_set();
        t_sw_clear();
        t_edge();
        t_clr_kinds();
        t_level();
        t_nmi();
        t_race();
        t_setclr();
        t_enable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule